// File: doc/BRIEF.md
# Bidirectional Gate Scan Shift Register

This block sequences the row-select lines of a thin-film display panel. A single start pulse is captured at one end of a chain of output stages. On every rising clock edge it moves one stage along, so exactly one scan output is high per line time. A direction input picks which end takes the pulse and which end passes it on. The two end ports are bidirectional, which lets several devices be chained in either scan order.

A count-select input shortens the chain from 154 to 150 active outputs. In that mode four stages in the middle are bypassed, so the pulse jumps across them and their outputs stay low. The carry-out towards the next device is registered on the falling clock edge, half a cycle after the last stage goes high. Three blanking inputs each force one third of the outputs low at once, without waiting for the clock. While an output is blanked, the shift register keeps running.

Top module: `gate_scan_shifter`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), every stage is cleared, all of `scan_out` reads 0 and the carry-out reads 0.
- R2: With `shift_up` = 1, the level on `end_r` is captured at a rising edge and appears on `scan_out[0]` after that edge. Each later rising edge moves it one index upward, towards `scan_out[153]`.
- R3: With `shift_up` = 0, the level on `end_l` is captured at a rising edge and appears on `scan_out[153]`. Each later rising edge moves it one index downward, towards `scan_out[0]`.
- R4: With `shift_up` = 1, `end_l` carries the carry-out and `end_r` is high-impedance, so it can be used as an input. With `shift_up` = 0 the roles are swapped.
- R5: With `short_mode` = 0, a pulse captured at rising edge 1 raises the carry-out at the 154th falling edge counted from that capture, and drops it at the 155th.
- R6: With `short_mode` = 1, the same pulse raises the carry-out at the 150th falling edge and drops it at the 151st.
- R7: With `short_mode` = 1, `scan_out[78:75]` (outputs 76 to 79) are always 0. The pulse passes directly between index 74 and index 79, in either direction.
- R8: `blank[g]` = 1 forces low, with no clock edge needed, every `scan_out[i]` with i mod 3 = g. Outputs of other groups are unaffected.
- R9: Blanking does not change the shift register. When `blank` is released, the outputs show the pulse at the stage it would have reached without blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages on rising edge, carry on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_up | input | 1 | 1: pulse enters at `end_r`, moves to higher indices; 0: enters at `end_l`, moves down |
| short_mode | input | 1 | 1: 150 active outputs with indices 75..78 bypassed; 0: 154 outputs |
| blank | input | 3 | Asynchronous output blanking, one bit per index-mod-3 group |
| end_r | inout | 1 | Start input when `shift_up`=1, carry-out otherwise |
| end_l | inout | 1 | Carry-out when `shift_up`=1, start input otherwise |
| scan_out | output | 154 | Scan outputs, index i is output i+1 |

## Verification
Isolated single pulses are sent in each of the four direction and count combinations. These show whether the stage order is right, whether the bypass holds in both directions, and on which falling edge the carry-out rises and falls. Blanking is applied mid-travel with one group hiding the pulse and the other groups not hiding it. This separates blanking that gates only the outputs from blanking that disturbs the register, and shows that the effect is immediate. Long random trains of pulses, with direction, count mode and blanking switched at random, are compared against an independent stage model. They catch mistakes in the wiring between neighbouring stages and in port steering that a lone pulse would not reach.

// File: rtl/gss_pkg.sv
package gss_pkg;

    typedef enum logic {
        SHIFT_DOWN = 1'b0,
        SHIFT_UP   = 1'b1
    } shift_dir_e;

    // True when index idx lies inside the bypassed gap [first, first+count-1]
    function automatic logic in_gap(input int idx, input int first, input int count);
        return (idx >= first) && (idx < first + count);
    endfunction

endpackage

// File: rtl/gss_stage_chain.sv
module gss_stage_chain
    import gss_pkg::*;
#(
    parameter int NUM_OUT    = 154,
    parameter int SKIP_FIRST = 75,
    parameter int SKIP_COUNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_up,
    input  logic               short_mode,
    input  logic               shift_in,
    output logic [NUM_OUT-1:0] stage_q
);

    localparam int SKIP_LAST = SKIP_FIRST + SKIP_COUNT - 1;

    typedef struct packed {
        logic [NUM_OUT-1:0] stage;
    } chain_t;

    chain_t chain_d, chain_q;

    logic [NUM_OUT-1:0] from_below;  // neighbour value when shifting up
    logic [NUM_OUT-1:0] from_above;  // neighbour value when shifting down
    logic [NUM_OUT-1:0] gap_mask;
    shift_dir_e         dir;

    assign dir = shift_dir_e'(shift_up);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_link
        if (i == 0) begin : g_lo_end
            assign from_below[i] = shift_in;
        end else if (i == SKIP_LAST + 1) begin : g_lo_jump
            assign from_below[i] = short_mode ? chain_q.stage[SKIP_FIRST-1] : chain_q.stage[i-1];
        end else begin : g_lo_norm
            assign from_below[i] = chain_q.stage[i-1];
        end

        if (i == NUM_OUT - 1) begin : g_hi_end
            assign from_above[i] = shift_in;
        end else if (i == SKIP_FIRST - 1) begin : g_hi_jump
            assign from_above[i] = short_mode ? chain_q.stage[SKIP_LAST+1] : chain_q.stage[i+1];
        end else begin : g_hi_norm
            assign from_above[i] = chain_q.stage[i+1];
        end

        assign gap_mask[i] = in_gap(i, SKIP_FIRST, SKIP_COUNT);
    end

    always_comb begin
        chain_d = chain_q;
        chain_d.stage = (dir == SHIFT_UP) ? from_below : from_above;
        if (short_mode) begin
            chain_d.stage = chain_d.stage & ~gap_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign stage_q = chain_q.stage;

endmodule

// File: rtl/gss_carry_reg.sv
module gss_carry_reg
    import gss_pkg::*;
#(
    parameter int NUM_OUT = 154
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_up,
    input  logic [NUM_OUT-1:0] stage_q,
    output logic               carry_q
);

    typedef struct packed {
        logic carry;
    } carry_t;

    carry_t carry_d, carry_r;

    always_comb begin
        carry_d = carry_r;
        carry_d.carry = (shift_dir_e'(shift_up) == SHIFT_UP) ? stage_q[NUM_OUT-1] : stage_q[0];
    end

    // Falling-edge register: half a cycle after the last stage rises
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_r <= '0;
        end else begin
            carry_r <= carry_d;
        end
    end

    assign carry_q = carry_r.carry;

endmodule

// File: rtl/gss_out_blank.sv
module gss_out_blank
    import gss_pkg::*;
#(
    parameter int NUM_OUT    = 154,
    parameter int NUM_EN     = 3,
    parameter int SKIP_FIRST = 75,
    parameter int SKIP_COUNT = 4
) (
    input  logic [NUM_OUT-1:0] stage_q,
    input  logic [NUM_EN-1:0]  blank,
    input  logic               short_mode,
    output logic [NUM_OUT-1:0] scan_out
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
        localparam int GROUP = i % NUM_EN;
        if (in_gap(i, SKIP_FIRST, SKIP_COUNT)) begin : g_gap
            assign scan_out[i] = stage_q[i] & ~blank[GROUP] & ~short_mode;
        end else begin : g_plain
            assign scan_out[i] = stage_q[i] & ~blank[GROUP];
        end
    end

endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter
    import gss_pkg::*;
#(
    parameter int NUM_OUT    = 154,
    parameter int NUM_EN     = 3,
    parameter int SKIP_FIRST = 75,
    parameter int SKIP_COUNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_up,
    input  logic               short_mode,
    input  logic [NUM_EN-1:0]  blank,
    inout  wire                end_r,
    inout  wire                end_l,
    output logic [NUM_OUT-1:0] scan_out
);

    logic               shift_in;
    logic               carry_q;
    logic [NUM_OUT-1:0] stage_q;

    // Port steering: the entry end listens, the far end drives the carry
    assign shift_in = shift_up ? end_r : end_l;
    assign end_l    = shift_up ? carry_q : 1'bz;
    assign end_r    = shift_up ? 1'bz : carry_q;

    gss_stage_chain #(
        .NUM_OUT   (NUM_OUT),
        .SKIP_FIRST(SKIP_FIRST),
        .SKIP_COUNT(SKIP_COUNT)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_up  (shift_up),
        .short_mode(short_mode),
        .shift_in  (shift_in),
        .stage_q   (stage_q)
    );

    gss_carry_reg #(
        .NUM_OUT(NUM_OUT)
    ) u_carry (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_up(shift_up),
        .stage_q (stage_q),
        .carry_q (carry_q)
    );

    gss_out_blank #(
        .NUM_OUT   (NUM_OUT),
        .NUM_EN    (NUM_EN),
        .SKIP_FIRST(SKIP_FIRST),
        .SKIP_COUNT(SKIP_COUNT)
    ) u_blank (
        .stage_q   (stage_q),
        .blank     (blank),
        .short_mode(short_mode),
        .scan_out  (scan_out)
    );

endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
    parameter int NUM_OUT    = 154,
    parameter int NUM_EN     = 3,
    parameter int SKIP_FIRST = 75,
    parameter int SKIP_COUNT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               shift_up,
    input logic               short_mode,
    input logic [NUM_EN-1:0]  blank,
    input logic               end_r,
    input logic               end_l,
    input logic [NUM_OUT-1:0] scan_out,
    input logic [NUM_OUT-1:0] stage_q
);

    localparam int SKIP_LAST = SKIP_FIRST + SKIP_COUNT - 1;

    logic [NUM_OUT-1:0] blank_leak;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_leak
        assign blank_leak[i] = blank[i % NUM_EN] & scan_out[i];
    end

    // R2: upward shift moves every stage one index up, entry from end_r
    a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_up && !short_mode) |=>
            (stage_q[NUM_OUT-1:1] == $past(stage_q[NUM_OUT-2:0])) && (stage_q[0] == $past(end_r)));

    // R3: downward shift moves every stage one index down, entry from end_l
    a_r3_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_up && !short_mode) |=>
            (stage_q[NUM_OUT-2:0] == $past(stage_q[NUM_OUT-1:1])) && (stage_q[NUM_OUT-1] == $past(end_l)));

    // R4: far port carries the registered last stage of the active direction
    a_r4_carry_port: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(shift_up) && shift_up) |-> (end_l == stage_q[NUM_OUT-1]));

    // R7: bypassed outputs stay low in short mode
    a_r7_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
        short_mode |-> (scan_out[SKIP_LAST:SKIP_FIRST] == '0));

    // R7: pulse jumps across the gap in short mode
    a_r7_gap_jump_up: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_up && short_mode) |=> (stage_q[SKIP_LAST+1] == $past(stage_q[SKIP_FIRST-1])));

    a_r7_gap_jump_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_up && short_mode) |=> (stage_q[SKIP_FIRST-1] == $past(stage_q[SKIP_LAST+1])));

    // R8: no output of a blanked group is high
    a_r8_blank_group: assert property (@(posedge clk) disable iff (!rst_n)
        blank_leak == '0);

endmodule

bind gate_scan_shifter gss_checker #(
    .NUM_OUT   (NUM_OUT),
    .NUM_EN    (NUM_EN),
    .SKIP_FIRST(SKIP_FIRST),
    .SKIP_COUNT(SKIP_COUNT)
) u_gss_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_up  (shift_up),
    .short_mode(short_mode),
    .blank     (blank),
    .end_r     (end_r),
    .end_l     (end_l),
    .scan_out  (scan_out),
    .stage_q   (stage_q)
);

// File: tb/test_gate_scan_shifter.sv
module test_gate_scan_shifter;

    localparam int PERIOD = 10;
    localparam int N      = 154;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         shift_up = 1'b1;
    logic         short_mode = 1'b0;
    logic [2:0]   blank = 3'b000;
    logic         start_bit = 1'b0;
    logic [N-1:0] scan_out;
    wire          end_r;
    wire          end_l;

    int n_chk = 0;
    int n_fail = 0;

    logic [N-1:0] m = '0;   // model of stage contents
    logic         c = 1'b0; // model of carry register
    logic         last_pre, last_post;

    assign end_r = shift_up ? start_bit : 1'bz;
    assign end_l = shift_up ? 1'bz : start_bit;

    always #(PERIOD/2) clk = ~clk;

    gate_scan_shifter i_gate_scan_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_up  (shift_up),
        .short_mode(short_mode),
        .blank     (blank),
        .end_r     (end_r),
        .end_l     (end_l),
        .scan_out  (scan_out)
    );

    function automatic logic [N-1:0] model_next(input logic [N-1:0] cur, input logic din,
                                                input logic up, input logic shrt);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (up) begin
                if (i == 0) r[i] = din;
                else if (shrt && i == 79) r[i] = cur[74];
                else r[i] = cur[i-1];
            end else begin
                if (i == N-1) r[i] = din;
                else if (shrt && i == 74) r[i] = cur[79];
                else r[i] = cur[i+1];
            end
            if (shrt && i >= 75 && i <= 78) r[i] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] gated(input logic [N-1:0] st, input logic [2:0] bl,
                                           input logic shrt);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            r[i] = st[i] & ~bl[i % 3] & ~(shrt && i >= 75 && i <= 78);
        end
        return r;
    endfunction

    function automatic logic carry_port();
        return shift_up ? end_l : end_r;
    endfunction

    function automatic logic input_port();
        return shift_up ? end_r : end_l;
    endfunction

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // One rising edge; returns at posedge+7 (after the falling edge)
    task automatic step(input string tag);
        logic [N-1:0] nxt;
        nxt = model_next(m, start_bit, shift_up, short_mode);
        @(posedge clk);
        m = nxt;
        #2;
        check_vec(tag, scan_out, gated(m, blank, short_mode));
        check_bit("R4 entry port not driven by design", input_port(), start_bit);
        last_pre = carry_port();
        check_bit("R4 carry before falling edge", last_pre, c);
        #5;
        c = shift_up ? m[N-1] : m[0];
        last_post = carry_port();
        check_bit("R4 carry after falling edge", last_post, c);
    endtask

    // Single pulse through the whole chain with carry edge counting
    task automatic run_pulse(input logic up, input logic shrt, input string tag, input string ctag);
        int len;
        len = shrt ? 150 : 154;
        shift_up = up;
        short_mode = shrt;
        start_bit = 1'b1;
        step(tag);
        start_bit = 1'b0;
        check_bit({tag, " first stage"}, scan_out[up ? 0 : N-1], 1'b1);
        for (int k = 2; k <= len + 2; k++) begin
            step(tag);
            if (k == len) begin
                check_bit({ctag, " carry low before rising falling-edge"}, last_pre, 1'b0);
                check_bit({ctag, " carry rises on final falling edge"}, last_post, 1'b1);
            end
            if (k == len + 1) begin
                check_bit({ctag, " carry falls on next falling edge"}, last_post, 1'b0);
            end
            if (shrt && k == 76) begin
                check_bit("R7 pulse jumps gap", scan_out[up ? 79 : 74], 1'b1);
            end
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check_vec("R1 reset outputs", scan_out, '0);
        check_bit("R1 reset carry", carry_port(), 1'b0);
        rst_n = 1'b1;
        #5;

        run_pulse(1'b1, 1'b0, "R2 upward full", "R5");
        run_pulse(1'b0, 1'b0, "R3 downward full", "R5");
        run_pulse(1'b1, 1'b1, "R7 upward short", "R6");
        run_pulse(1'b0, 1'b1, "R7 downward short", "R6");

        // Blanking: group effect, asynchronous action, register retention
        shift_up = 1'b1;
        short_mode = 1'b0;
        start_bit = 1'b1;
        step("R2 blank setup");
        start_bit = 1'b0;
        for (int k = 2; k <= 17; k++) step("R2 blank setup");
        blank = 3'b101;
        #1;
        check_vec("R8 other groups leave pulse visible", scan_out, N'(1) << 16);
        blank = 3'b010;
        #1;
        check_vec("R8 own group blanks without clock", scan_out, '0);
        for (int k = 0; k < 5; k++) step("R8 blanked travel");
        blank = 3'b000;
        #1;
        check_vec("R9 pulse kept moving under blank", scan_out, N'(1) << 21);
        blank = 3'b111;
        #1;
        check_vec("R8 all groups blank", scan_out, '0);
        blank = 3'b000;
        for (int k = 0; k < 140; k++) step("R9 flush after blank");

        // Random trains with switching direction, mode and blanking
        for (int cyc = 0; cyc < 900; cyc++) begin
            if ($urandom % 64 == 0) shift_up = ~shift_up;
            if ($urandom % 97 == 0) short_mode = ~short_mode;
            start_bit = ($urandom % 11 == 0);
            blank = ($urandom % 8 == 0) ? 3'($urandom) : 3'b000;
            step("R2 R3 R7 R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule